// File: doc/BRIEF.md
# Multi-Channel Interrupt Status Aggregator

This block gathers the pending-interrupt flags of eight serial channels, plus two device-wide requests from a timer and a multipurpose I/O port. It folds them into one 32-bit read-only status word. A host interrupt handler reads that word in a single access. The low byte is a one-hot map of which channels need service. The upper 24 bits give each channel a 3-bit code that names its most urgent pending source. The device-wide requests show up only in channel 0's code.

A wake-from-sleep event raises the combined interrupt line on its own. It leaves no trace in the status word, and a host read that covers the summary byte clears it. The status word and the interrupt line are both registered, so they follow the inputs with one clock of latency. Reads never clear channel state: a channel's bits drop only when its source inputs drop.

Top module: `irq_status_agg`

## Requirements
- R1: While reset is asserted and in the first cycle after it, with no source active, `status_o` is 0x00000000 and `irq_o` is 0.
- R2: Bit n of `status_o[7:0]` is 1 exactly when channel n has any source pending. For channel 0 the timer and the multipurpose I/O request also count as sources.
- R3: Channel n's code occupies `status_o[3n+10:3n+8]`: channel 0 in [10:8] and channel 7 in [31:29].
- R4: The code reports the highest-priority pending source of its channel, using the codes line status = 3'b001, receive data = 3'b010, receive timeout = 3'b011, transmit empty = 3'b100, modem status = 3'b101, multipurpose I/O = 3'b110 and timer = 3'b111. 3'b000 means nothing is pending. A smaller nonzero code has the higher priority.
- R5: The codes 3'b110 and 3'b111 appear only in channel 0's field. The timer and multipurpose I/O requests change no other channel's field or summary bit.
- R6: Host reads, at any byte address, leave the summary byte and the code fields unchanged.
- R7: A rising edge on `wake_i` sets a wake flag that drives `irq_o` to 1 and changes no bit of `status_o`. Holding `wake_i` high does not set the flag again once it has been cleared.
- R8: A read with `rd_en_i` = 1 and `rd_addr_i` = 2'b00 (the access covers the summary byte) clears the wake flag. Reads at addresses 1 to 3 do not clear it.
- R9: If a summary-byte read and a new rising edge of `wake_i` occur in the same cycle, the wake flag stays set.
- R10: `irq_o` is the OR of all summary bits and the wake flag. It is registered, and so is `status_o`: both reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_stat_i | input | 8 | Per-channel line status pending |
| rx_data_i | input | 8 | Per-channel receive data ready |
| rx_tmo_i | input | 8 | Per-channel receive timeout |
| tx_empty_i | input | 8 | Per-channel transmit empty |
| modem_stat_i | input | 8 | Per-channel modem status pending |
| mpio_irq_i | input | 1 | Device-wide multipurpose I/O request |
| timer_irq_i | input | 1 | Device-wide timer request |
| wake_i | input | 1 | Wake-from-sleep event level |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 2 | Byte address of the lowest byte the read covers |
| status_o | output | 32 | Aggregated status word |
| irq_o | output | 1 | Combined interrupt line |

## Verification
Each source is first driven alone on every channel. This shows whether each code lands at the right bit position and whether the summary bit follows it. Every channel then has all of its sources raised together, and they are removed one at a time from the top. This separates a correct priority order from a merely plausible one. The timer and multipurpose I/O requests are mixed with channel-0 sources and with sources on other channels, to expose any leakage out of field 0. Finally, a wake sequence combines reads at each address, a held wake level and a read that coincides with a new wake edge, followed by a long random mix. Together these test the clear-versus-set ordering of the wake flag and the one-cycle latency.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NUM_CH = 8;
  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE  = 3'd0,
    CODE_LINE  = 3'd1,
    CODE_RXD   = 3'd2,
    CODE_RXTO  = 3'd3,
    CODE_TXE   = 3'd4,
    CODE_MODEM = 3'd5,
    CODE_MPIO  = 3'd6,
    CODE_TIMER = 3'd7
  } irq_code_e;

  typedef struct packed {
    logic line;
    logic rxd;
    logic rxto;
    logic txe;
    logic modem;
  } ch_src_t;
endpackage

// File: rtl/irq_chan_enc.sv
module irq_chan_enc
  import irq_agg_pkg::*;
(
  input  ch_src_t   src_i,
  input  logic      dev_mpio_i,
  input  logic      dev_timer_i,
  output irq_code_e code_o,
  output logic      pend_o
);
  always_comb begin
    if (src_i.line)       code_o = CODE_LINE;
    else if (src_i.rxd)   code_o = CODE_RXD;
    else if (src_i.rxto)  code_o = CODE_RXTO;
    else if (src_i.txe)   code_o = CODE_TXE;
    else if (src_i.modem) code_o = CODE_MODEM;
    else if (dev_mpio_i)  code_o = CODE_MPIO;
    else if (dev_timer_i) code_o = CODE_TIMER;
    else                  code_o = CODE_NONE;
  end

  assign pend_o = (|src_i) | dev_mpio_i | dev_timer_i;
endmodule

// File: rtl/irq_wake_ctl.sv
module irq_wake_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  input  logic clr_i,
  output logic flag_o,
  output logic flag_nxt_o
);
  logic wake_d_q;
  logic flag_q;
  logic rise;

  assign rise = wake_i & ~wake_d_q;
  // a new edge wins over a same-cycle clear
  assign flag_nxt_o = rise | (flag_q & ~clr_i);
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_d_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      wake_d_q <= wake_i;
      flag_q   <= flag_nxt_o;
    end
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  localparam int unsigned WORD_W = N_CH + N_CH * CODE_W,
  localparam int unsigned ADDR_W = $clog2(WORD_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   line_stat_i,
  input  logic [N_CH-1:0]   rx_data_i,
  input  logic [N_CH-1:0]   rx_tmo_i,
  input  logic [N_CH-1:0]   tx_empty_i,
  input  logic [N_CH-1:0]   modem_stat_i,
  input  logic              mpio_irq_i,
  input  logic              timer_irq_i,
  input  logic              wake_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] status_o,
  output logic              irq_o
);
  logic [N_CH-1:0] pend_d;
  logic [N_CH-1:0] sum_q;
  irq_code_e       code_d [N_CH];
  irq_code_e       code_q [N_CH];
  logic            wake_flag;
  logic            wake_nxt;
  logic            rd_sum;
  logic            irq_q;

  assign rd_sum = rd_en_i & (rd_addr_i == '0);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    ch_src_t src;
    assign src = '{line:  line_stat_i[g],
                   rxd:   rx_data_i[g],
                   rxto:  rx_tmo_i[g],
                   txe:   tx_empty_i[g],
                   modem: modem_stat_i[g]};

    irq_chan_enc u_enc (
      .src_i       (src),
      .dev_mpio_i  ((g == 0) ? mpio_irq_i  : 1'b0),
      .dev_timer_i ((g == 0) ? timer_irq_i : 1'b0),
      .code_o      (code_d[g]),
      .pend_o      (pend_d[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) code_q[g] <= CODE_NONE;
      else         code_q[g] <= code_d[g];
    end

    assign status_o[N_CH + g*CODE_W +: CODE_W] = code_q[g];
  end

  irq_wake_ctl u_wake (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wake_i     (wake_i),
    .clr_i      (rd_sum),
    .flag_o     (wake_flag),
    .flag_nxt_o (wake_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sum_q <= pend_d;
      irq_q <= (|pend_d) | wake_nxt;
    end
  end

  assign status_o[N_CH-1:0] = sum_q;
  assign irq_o = irq_q;

  logic unused_flag;
  assign unused_flag = wake_flag;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  localparam int unsigned WORD_W = N_CH + N_CH * CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CH-1:0]   line_stat_i,
  input logic [N_CH-1:0]   rx_data_i,
  input logic [N_CH-1:0]   rx_tmo_i,
  input logic [N_CH-1:0]   tx_empty_i,
  input logic [N_CH-1:0]   modem_stat_i,
  input logic              mpio_irq_i,
  input logic              timer_irq_i,
  input logic              wake_i,
  input logic              rd_sum_i,
  input logic [WORD_W-1:0] status_o,
  input logic              irq_o
);
  logic any_src;
  assign any_src = (|line_stat_i) | (|rx_data_i) | (|rx_tmo_i) | (|tx_empty_i)
                 | (|modem_stat_i) | mpio_irq_i | timer_irq_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam int unsigned LO = N_CH + g * CODE_W;

    assert_line_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_stat_i[g] |=> status_o[LO +: CODE_W] == CODE_LINE);

    assert_sum_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (line_stat_i[g] | rx_data_i[g] | rx_tmo_i[g] | tx_empty_i[g] | modem_stat_i[g])
      |=> status_o[g]);

    if (g > 0) begin : g_upper
      assert_no_dev_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(status_o[LO+2] & status_o[LO+1]));
    end
  end

  assert_sum_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_o[N_CH-1:0]) |-> irq_o);

  assert_wake_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_i) |=> irq_o);

  assert_wake_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sum_i && !wake_i && !any_src) |=> !irq_o);

  assert_wake_race_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sum_i && $rose(wake_i)) |=> irq_o);
endmodule

bind irq_status_agg irq_agg_chk #(.N_CH(N_CH)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_stat_i  (line_stat_i),
  .rx_data_i    (rx_data_i),
  .rx_tmo_i     (rx_tmo_i),
  .tx_empty_i   (tx_empty_i),
  .modem_stat_i (modem_stat_i),
  .mpio_irq_i   (mpio_irq_i),
  .timer_irq_i  (timer_irq_i),
  .wake_i       (wake_i),
  .rd_sum_i     (rd_en_i && (rd_addr_i == '0)),
  .status_o     (status_o),
  .irq_o        (irq_o)
);

// File: tb/irq_status_agg_tb_top.sv
`timescale 1ns/1ps
module irq_status_agg_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  line_v = '0, rxd_v = '0, tmo_v = '0, txe_v = '0, mdm_v = '0;
  logic        mpio = 1'b0, timer = 1'b0, wake = 1'b0, rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] status;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic        m_wake = 1'b0, m_prev = 1'b0;
  logic [31:0] last_word = '0;

  always #2.5 clk_i = ~clk_i;

  irq_status_agg dut_i (
    .clk_i, .rst_ni,
    .line_stat_i (line_v), .rx_data_i (rxd_v), .rx_tmo_i (tmo_v),
    .tx_empty_i (txe_v), .modem_stat_i (mdm_v),
    .mpio_irq_i (mpio), .timer_irq_i (timer), .wake_i (wake),
    .rd_en_i (rd_en), .rd_addr_i (rd_addr),
    .status_o (status), .irq_o (irq)
  );

  function automatic logic [2:0] ref_code(int n);
    if (line_v[n]) return 3'd1;
    if (rxd_v[n])  return 3'd2;
    if (tmo_v[n])  return 3'd3;
    if (txe_v[n])  return 3'd4;
    if (mdm_v[n])  return 3'd5;
    if (n == 0 && mpio)  return 3'd6;
    if (n == 0 && timer) return 3'd7;
    return 3'd0;
  endfunction

  task automatic chk_word(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s status_o got %08h exp %08h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s irq_o got %0b exp %0b", tag, act, exp);
    end
  endtask

  // inputs already set at a negedge; model the next edge, then compare
  task automatic step(string tag);
    logic [31:0] ew;
    logic rise, wn, ei;
    ew = '0;
    for (int n = 0; n < 8; n++) begin
      logic [2:0] c;
      c = ref_code(n);
      ew[8 + 3*n +: 3] = c;
      ew[n] = (c != 3'd0);
    end
    rise = wake & ~m_prev;
    wn = rise | (m_wake & ~(rd_en && rd_addr == 2'd0));
    ei = (|ew[7:0]) | wn;
    chk_word("R10 (pre-edge hold)", status, last_word);
    @(posedge clk_i);
    @(negedge clk_i);
    chk_word(tag, status, ew);
    chk_bit(tag, irq, ei);
    m_wake = wn;
    m_prev = wake;
    last_word = ew;
  endtask

  task automatic clr_all();
    line_v = '0; rxd_v = '0; tmo_v = '0; txe_v = '0; mdm_v = '0;
    mpio = 0; timer = 0; wake = 0; rd_en = 0; rd_addr = '0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_word("R1", status, 32'h0);
    chk_bit("R1", irq, 1'b0);
    rst_ni = 1'b1;
    step("R1");

    // single source per channel: position and summary
    for (int n = 0; n < 8; n++) begin
      for (int s = 0; s < 5; s++) begin
        clr_all();
        case (s)
          0: line_v[n] = 1;
          1: rxd_v[n]  = 1;
          2: tmo_v[n]  = 1;
          3: txe_v[n]  = 1;
          default: mdm_v[n] = 1;
        endcase
        step("R3");
      end
    end
    clr_all(); step("R2");

    // priority: all raised, strip from the top
    for (int n = 0; n < 8; n++) begin
      line_v[n] = 1; rxd_v[n] = 1; tmo_v[n] = 1; txe_v[n] = 1; mdm_v[n] = 1;
      step("R4");
      line_v[n] = 0; step("R4");
      rxd_v[n]  = 0; step("R4");
      tmo_v[n]  = 0; step("R4");
      txe_v[n]  = 0; step("R4");
      mdm_v[n]  = 0; step("R2");
    end

    // device-wide sources
    clr_all();
    timer = 1; step("R5");
    mpio = 1;  step("R5");
    mdm_v[3] = 1; step("R5");
    mdm_v[0] = 1; step("R4");
    line_v[0] = 1; step("R4");
    clr_all(); mpio = 1; step("R5");
    clr_all(); step("R5");

    // reads do not clear channel state
    line_v[2] = 1; txe_v[5] = 1; timer = 1;
    step("R6");
    for (int a = 0; a < 4; a++) begin
      rd_en = 1; rd_addr = 2'(a); step("R6");
    end
    clr_all(); step("R6");

    // wake flag
    wake = 1; step("R7");
    step("R7");
    rd_en = 1; rd_addr = 2'd1; step("R8");
    rd_addr = 2'd3; step("R8");
    rd_addr = 2'd0; step("R8");
    rd_en = 0; step("R7");
    wake = 0; step("R7");
    wake = 1; rd_en = 1; rd_addr = 2'd0; step("R9");
    rd_en = 0; step("R9");
    rd_en = 1; step("R8");
    clr_all(); mdm_v[6] = 1; wake = 1; step("R7");
    rd_en = 1; step("R8");
    clr_all(); step("R8");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 7);
      line_v = 8'($urandom) & 8'($urandom) & 8'($urandom);
      rxd_v  = 8'($urandom) & 8'($urandom);
      tmo_v  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      txe_v  = 8'($urandom) & 8'($urandom);
      mdm_v  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      if (r == 0) begin line_v = '0; rxd_v = '0; tmo_v = '0; txe_v = '0; mdm_v = '0; end
      mpio  = 1'($urandom);
      timer = 1'($urandom);
      if ($urandom_range(0, 3) == 0) wake = ~wake;
      rd_en = 1'($urandom);
      rd_addr = 2'($urandom);
      step("R10");
    end

    finish_run();
  end
endmodule